// File: doc/BRIEF.md
# Interrupt Distributor State Register Bank

This block keeps the per-source state of a shared interrupt distributor and exposes it through a plain 32-bit register read/write port. Every interrupt source has an enable bit, a pending bit, an active bit, a trigger-mode flag and a CPU target mask. Each of the three state bits can be reached through two addresses. One address sets bits where the written word holds a one. The other clears them. Reading either address returns the current state. Sources 0-31 are private. Every CPU interface owns its own copy of their state. The interface making an access is named on the `acc_cpu` input.

Hardware sources raise pending bits. A level-mode source keeps its pending bit set for as long as its input is high. An edge-mode source sets it only when its input rises. A global control bit gates the per-CPU request outputs, which report whether any source is enabled, pending, not active and aimed at that CPU. A read-only word reports the configured number of sources. Priority arbitration, acknowledge handling and bus adaptation are handled elsewhere.

Top module: `ids_state_bank`

## Requirements
- R1: After reset every enable, pending, active, trigger and target bit is zero, the control bit is zero, `rd_data` is zero and `fwd_req` is all low.
- R2: Enable uses set/clear words at 0x100/0x180, pending uses 0x200/0x280 and active uses 0x300/0x380. Source n sits in bit n%32 of the word at offset (n/32)*4. A written 1 sets the bit (set word) or clears it (clear word). A written 0 changes nothing. Both words of a pair read back the same state.
- R3: For sources 0-31, enable, pending, active and trigger state is held separately for each CPU interface. An access by `acc_cpu` = c touches and returns only copy c.
- R4: The target mask of source n >= 32 is in byte n%4 of the word at 0x400 + (n & ~3). Only the low NUM_CPU bits of each byte are stored. The other bits, and bytes of sources that do not exist, read as zero.
- R5: The eight target words at 0x400-0x41C are read-only. Every byte reads 1 << acc_cpu, and writes to them are ignored.
- R6: Trigger mode of source n is bit 2*(n%16)+1 of the word at 0x800 + (n/16)*4, where 0 means level-high and 1 means rising edge. Bit 2*(n%16) always reads 0.
- R7: A level-mode source whose input is high sets its pending bit on every clock. A clear written while the input is high gives 0 on a read issued in the next cycle, and the bit is set again on the following clock.
- R8: An edge-mode source sets its pending bit only on a 0-to-1 change of its input sampled on `clk`. A held-high input does not set it again after a clear.
- R9: The word at 0x004 reads NUM_IRQ/32-1 in bits 4:0 and zero elsewhere.
- R10: Bit 0 of the word at 0x000 is the global enable. `fwd_req[c]` is high exactly when that bit is 1 and some source is enabled, pending and not active. For a private source the copy must be CPU c's. For a shared source its target mask must have bit c set.
- R11: `rd_data` takes the value addressed by a read in the cycle after `rd_en`, and unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| acc_cpu | input | CPUW | CPU interface making the access |
| addr | input | 12 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| irq_shared | input | NUM_IRQ-32 | Shared sources, bit 0 is source 32 |
| irq_private | input | NUM_CPU*32 | Private sources, bits [c*32+31:c*32] belong to CPU c |
| fwd_req | output | NUM_CPU | Per-CPU request, gated by the global enable |

## Verification
A wrong state bit reaches the ports one cycle after a read of its word, or at once on `fwd_req` when it changes whether a source is forwardable. A banking fault, where one CPU's private copy leaks into another's, shows only when the other interface reads the same offset. The bench therefore reads every private offset from both interfaces. A level source that fails to re-arm, or an edge source that re-arms, shows only on a read issued in the cycle right after a clear and again one clock later. The bench places reads at exactly those two points.

// File: rtl/ids_pkg.sv
package ids_pkg;

  typedef enum logic [2:0] {
    OP_EN_SET = 3'd0,
    OP_EN_CLR = 3'd1,
    OP_PD_SET = 3'd2,
    OP_PD_CLR = 3'd3,
    OP_AC_SET = 3'd4,
    OP_AC_CLR = 3'd5,
    OP_NONE   = 3'd7
  } bitop_e;

  localparam logic [11:0] A_CTL  = 12'h000;
  localparam logic [11:0] A_TYPE = 12'h004;

  // Offsets 0x100..0x3FF map onto the six set/clear words.
  function automatic bitop_e op_of_addr(input logic [11:0] a);
    if (a[11:10] == 2'b00 && a[9:7] >= 3'd2)
      return bitop_e'(a[9:7] - 3'd2);
    return OP_NONE;
  endfunction

  function automatic logic [31:0] type_value(input int nirq);
    return 32'(nirq / 32 - 1);
  endfunction

  function automatic logic [31:0] priv_target(input int cpu);
    logic [7:0] b;
    b = 8'd1 << cpu;
    return {4{b}};
  endfunction

  // Sixteen trigger flags to a configuration word: flag j sits at bit 2j+1.
  function automatic logic [31:0] cfg_read(input logic [15:0] flags);
    logic [31:0] w;
    w = '0;
    for (int j = 0; j < 16; j++) w[2*j+1] = flags[j];
    return w;
  endfunction

  function automatic logic [15:0] cfg_write(input logic [31:0] w);
    logic [15:0] f;
    for (int j = 0; j < 16; j++) f[j] = w[2*j+1];
    return f;
  endfunction

endpackage

// File: rtl/ids_bitbank.sv
module ids_bitbank
  import ids_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  bitop_e      op,
  input  logic [1:0]  cfg_we,
  input  logic [31:0] wdata,
  input  logic [31:0] src,
  output logic [31:0] en,
  output logic [31:0] pd,
  output logic [31:0] ac,
  output logic [31:0] trig_edge
);

  logic [31:0] src_q;
  logic [31:0] hw_set;
  logic [31:0] m_es, m_ec, m_ps, m_pc, m_as, m_ac;

  // Write masks per alias; a word that is not selected contributes nothing.
  always_comb begin
    m_es = (we && op == OP_EN_SET) ? wdata : '0;
    m_ec = (we && op == OP_EN_CLR) ? wdata : '0;
    m_ps = (we && op == OP_PD_SET) ? wdata : '0;
    m_pc = (we && op == OP_PD_CLR) ? wdata : '0;
    m_as = (we && op == OP_AC_SET) ? wdata : '0;
    m_ac = (we && op == OP_AC_CLR) ? wdata : '0;
  end

  // Hardware pending request: rising edge in edge mode, high level otherwise.
  assign hw_set = (trig_edge & src & ~src_q) | (~trig_edge & src);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en        <= '0;
      pd        <= '0;
      ac        <= '0;
      trig_edge <= '0;
      src_q     <= '0;
    end else begin
      en    <= (en | m_es) & ~m_ec;
      pd    <= (pd | m_ps | hw_set) & ~m_pc;
      ac    <= (ac | m_as) & ~m_ac;
      src_q <= src;
      if (cfg_we[0]) trig_edge[15:0]  <= cfg_write(wdata);
      if (cfg_we[1]) trig_edge[31:16] <= cfg_write(wdata);
    end
  end

endmodule

// File: rtl/ids_target.sv
module ids_target #(
  parameter int NUM_CPU = 2,
  parameter int NSH     = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we,
  input  logic [7:0]                        word,
  input  logic [31:0]                       wdata,
  output logic [NSH-1:0][NUM_CPU-1:0]       tgt
);

  for (genvar i = 0; i < NSH; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        tgt[i] <= '0;
      else if (we && word == 8'(i / 4))
        tgt[i] <= wdata[(i % 4) * 8 +: NUM_CPU];
    end
  end

endmodule

// File: rtl/ids_forward.sv
module ids_forward #(
  parameter int NUM_CPU = 2,
  parameter int NSH     = 32
) (
  input  logic                          ctl_en,
  input  logic [NUM_CPU-1:0][31:0]      priv_rdy,
  input  logic [NSH-1:0]                sh_rdy,
  input  logic [NSH-1:0][NUM_CPU-1:0]   tgt,
  output logic [NUM_CPU-1:0]            fwd
);

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic hit;
    always_comb begin
      hit = |priv_rdy[c];
      for (int i = 0; i < NSH; i++) hit = hit | (sh_rdy[i] & tgt[i][c]);
    end
    assign fwd[c] = ctl_en & hit;
  end

endmodule

// File: rtl/ids_state_bank.sv
module ids_state_bank
  import ids_pkg::*;
#(
  parameter int NUM_CPU = 2,
  parameter int NUM_IRQ = 64,
  localparam int CPUW   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [CPUW-1:0]         acc_cpu,
  input  logic [11:0]             addr,
  input  logic [31:0]             wdata,
  output logic [31:0]             rd_data,
  input  logic [NUM_IRQ-33:0]     irq_shared,
  input  logic [NUM_CPU*32-1:0]   irq_private,
  output logic [NUM_CPU-1:0]      fwd_req
);

  localparam int NSH   = NUM_IRQ - 32;
  localparam int NSHW  = NSH / 32;
  localparam int NBANK = NUM_CPU + NSHW;

  // Decoded access fields, named for the checker.
  bitop_e     op;
  logic [4:0] bword;
  logic       is_tgt;
  logic [7:0] tword;
  logic       is_cfg;
  logic [5:0] cword;

  assign op     = op_of_addr(addr);
  assign bword  = addr[6:2];
  assign is_tgt = (addr[11:10] == 2'b01);
  assign tword  = addr[9:2];
  assign is_cfg = (addr[11:8] == 4'h8);
  assign cword  = addr[7:2];

  logic ctl_en;

  logic [NBANK-1:0][31:0] b_en, b_pd, b_ac, b_edge;

  // Banks 0..NUM_CPU-1 hold the private copies, the rest the shared sources.
  for (genvar k = 0; k < NBANK; k++) begin : g_bank
    logic        sel_w;
    logic [1:0]  sel_c;
    logic [31:0] src_k;
    if (k < NUM_CPU) begin : g_priv
      assign sel_w    = (bword == 5'd0) && (acc_cpu == CPUW'(k));
      assign sel_c[0] = (cword == 6'd0) && (acc_cpu == CPUW'(k));
      assign sel_c[1] = (cword == 6'd1) && (acc_cpu == CPUW'(k));
      assign src_k    = irq_private[k*32 +: 32];
    end else begin : g_sh
      assign sel_w    = (bword == 5'(k - NUM_CPU + 1));
      assign sel_c[0] = (cword == 6'(2 * (k - NUM_CPU + 1)));
      assign sel_c[1] = (cword == 6'(2 * (k - NUM_CPU + 1) + 1));
      assign src_k    = irq_shared[(k - NUM_CPU)*32 +: 32];
    end
    ids_bitbank u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (wr_en && op != OP_NONE && sel_w),
      .op        (op),
      .cfg_we    ({2{wr_en && is_cfg}} & sel_c),
      .wdata     (wdata),
      .src       (src_k),
      .en        (b_en[k]),
      .pd        (b_pd[k]),
      .ac        (b_ac[k]),
      .trig_edge (b_edge[k])
    );
  end

  // Shared state flattened by source number minus 32.
  logic [NSH-1:0] sh_en, sh_pd, sh_ac, sh_edge, sh_rdy;
  for (genvar k = 0; k < NSHW; k++) begin : g_flat
    assign sh_en[k*32 +: 32]   = b_en[NUM_CPU + k];
    assign sh_pd[k*32 +: 32]   = b_pd[NUM_CPU + k];
    assign sh_ac[k*32 +: 32]   = b_ac[NUM_CPU + k];
    assign sh_edge[k*32 +: 32] = b_edge[NUM_CPU + k];
  end
  assign sh_rdy = sh_en & sh_pd & ~sh_ac;

  logic [NUM_CPU-1:0][31:0] priv_rdy;
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_prdy
    assign priv_rdy[c] = b_en[c] & b_pd[c] & ~b_ac[c];
  end

  logic [NSH-1:0][NUM_CPU-1:0] tgt;

  ids_target #(.NUM_CPU(NUM_CPU), .NSH(NSH)) u_target (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en && is_tgt && tword >= 8'd8),
    .word  (tword - 8'd8),
    .wdata (wdata),
    .tgt   (tgt)
  );

  ids_forward #(.NUM_CPU(NUM_CPU), .NSH(NSH)) u_forward (
    .ctl_en   (ctl_en),
    .priv_rdy (priv_rdy),
    .sh_rdy   (sh_rdy),
    .tgt      (tgt),
    .fwd      (fwd_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctl_en <= 1'b0;
    else if (wr_en && addr == A_CTL)
      ctl_en <= wdata[0];
  end

  // Read selection.
  logic [31:0] rd_mux;
  int          bk;
  int          src_n;

  always_comb begin
    rd_mux = '0;
    bk     = -1;
    src_n  = 0;
    if (addr == A_CTL) begin
      rd_mux[0] = ctl_en;
    end else if (addr == A_TYPE) begin
      rd_mux = type_value(NUM_IRQ);
    end else if (op != OP_NONE) begin
      if (bword == 5'd0)
        bk = (int'(acc_cpu) < NUM_CPU) ? int'(acc_cpu) : -1;
      else if (int'(bword) <= NSHW)
        bk = NUM_CPU + int'(bword) - 1;
      if (bk >= 0) begin
        case (op)
          OP_EN_SET, OP_EN_CLR: rd_mux = b_en[bk];
          OP_PD_SET, OP_PD_CLR: rd_mux = b_pd[bk];
          default:              rd_mux = b_ac[bk];
        endcase
      end
    end else if (is_tgt) begin
      if (tword < 8'd8) begin
        rd_mux = priv_target(int'(acc_cpu));
      end else begin
        for (int j = 0; j < 4; j++) begin
          src_n = (int'(tword) - 8) * 4 + j;
          if (src_n < NSH) rd_mux[j*8 +: NUM_CPU] = tgt[src_n];
        end
      end
    end else if (is_cfg) begin
      if (cword[5:1] == 5'd0)
        bk = (int'(acc_cpu) < NUM_CPU) ? int'(acc_cpu) : -1;
      else if (int'(cword[5:1]) <= NSHW)
        bk = NUM_CPU + int'(cword[5:1]) - 1;
      if (bk >= 0)
        rd_mux = cfg_read(cword[0] ? b_edge[bk][31:16] : b_edge[bk][15:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rd_data <= '0;
    else if (rd_en)
      rd_data <= rd_mux;
  end

endmodule

// File: rtl/ids_state_chk.sv
module ids_state_chk #(
  parameter int NUM_CPU = 2,
  parameter int NUM_IRQ = 64,
  parameter int CPUW    = 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic                  rd_en,
  input logic [CPUW-1:0]       acc_cpu,
  input logic [11:0]           addr,
  input logic [31:0]           wdata,
  input logic [31:0]           rd_data,
  input logic [NUM_IRQ-33:0]   irq_shared,
  input logic [NUM_CPU-1:0]    fwd_req,
  input logic                  ctl_en,
  input logic [NUM_IRQ-33:0]   sh_en,
  input logic [NUM_IRQ-33:0]   sh_pd,
  input logic [NUM_IRQ-33:0]   sh_ac,
  input logic [NUM_IRQ-33:0]   sh_edge
);

  // R9
  type_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 12'h004) |=> rd_data == 32'(NUM_IRQ / 32 - 1));

  // R5
  priv_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr[11:10] == 2'b01 && addr[9:5] == 5'd0)
      |=> rd_data == {4{8'd1 << $past(acc_cpu)}});

  // R2
  enable_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 12'h104) |=> (sh_en[31:0] & $past(wdata)) == $past(wdata));

  // R2
  active_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 12'h384) |=> (sh_ac[31:0] & $past(wdata)) == 32'd0);

  // R7
  level_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sh_edge[0] && irq_shared[0] && !(wr_en && addr == 12'h284 && wdata[0]))
      |=> sh_pd[0]);

  // R10
  global_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |-> fwd_req == '0);

endmodule

bind ids_state_bank ids_state_chk #(
  .NUM_CPU (NUM_CPU),
  .NUM_IRQ (NUM_IRQ),
  .CPUW    (CPUW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .acc_cpu    (acc_cpu),
  .addr       (addr),
  .wdata      (wdata),
  .rd_data    (rd_data),
  .irq_shared (irq_shared),
  .fwd_req    (fwd_req),
  .ctl_en     (ctl_en),
  .sh_en      (sh_en),
  .sh_pd      (sh_pd),
  .sh_ac      (sh_ac),
  .sh_edge    (sh_edge)
);

// File: tb/test_ids_state_bank.sv
`timescale 1ns/1ps
module test_ids_state_bank;

  localparam int NUM_CPU = 2;
  localparam int NUM_IRQ = 64;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  wr_en = 1'b0;
  logic                  rd_en = 1'b0;
  logic [0:0]            acc_cpu = '0;
  logic [11:0]           addr = '0;
  logic [31:0]           wdata = '0;
  logic [31:0]           rd_data;
  logic [NUM_IRQ-33:0]   irq_shared = '0;
  logic [NUM_CPU*32-1:0] irq_private = '0;
  logic [NUM_CPU-1:0]    fwd_req;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] r;

  always #2.5 clk = ~clk;

  ids_state_bank #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ)) i_ids_state_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .acc_cpu(acc_cpu),
    .addr(addr), .wdata(wdata), .rd_data(rd_data), .irq_shared(irq_shared),
    .irq_private(irq_private), .fwd_req(fwd_req)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Every task starts and ends at a falling edge.
  task automatic wr(input int cpu, input logic [11:0] a, input logic [31:0] d);
    acc_cpu = 1'(cpu); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int cpu, input logic [11:0] a);
    acc_cpu = 1'(cpu); addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    r = rd_data;
  endtask

  task automatic t_reset;
    check("R1 rd_data", rd_data, 32'h0);
    check("R1 fwd_req", 32'(fwd_req), 32'h0);
    rd(0, 12'h000); check("R1 control", r, 32'h0);
    rd(0, 12'h204); check("R1 pending", r, 32'h0);
    rd(1, 12'h100); check("R1 private enable", r, 32'h0);
  endtask

  task automatic t_type;
    rd(0, 12'h004); check("R9 type word", r, 32'h1);
    rd(1, 12'h0FC); check("R11 unmapped", r, 32'h0);
  endtask

  task automatic t_setclr;
    wr(0, 12'h104, 32'h0000_00F0);
    rd(0, 12'h104); check("R2 enable set", r, 32'hF0);
    rd(0, 12'h184); check("R2 clear alias read", r, 32'hF0);
    wr(0, 12'h184, 32'h30);
    rd(0, 12'h104); check("R2 enable clear", r, 32'hC0);
    wr(0, 12'h104, 32'h0);
    wr(0, 12'h184, 32'h0);
    rd(0, 12'h104); check("R2 zero writes ignored", r, 32'hC0);
    wr(0, 12'h304, 32'h5);
    rd(0, 12'h384); check("R2 active set", r, 32'h5);
    wr(0, 12'h384, 32'h1);
    rd(0, 12'h304); check("R2 active clear", r, 32'h4);
    wr(0, 12'h384, 32'h4);
    wr(0, 12'h184, 32'hC0);
    rd(0, 12'h104); check("R2 cleanup", r, 32'h0);
  endtask

  task automatic t_bank;
    wr(0, 12'h100, 32'h20);
    rd(1, 12'h100); check("R3 other copy untouched", r, 32'h0);
    rd(0, 12'h100); check("R3 own copy", r, 32'h20);
    wr(1, 12'h800, 32'h2);
    rd(0, 12'h800); check("R3 trigger copy cpu0", r, 32'h0);
    rd(1, 12'h800); check("R3 trigger copy cpu1", r, 32'h2);
    wr(0, 12'h180, 32'h20);
    wr(1, 12'h800, 32'h0);
  endtask

  task automatic t_target;
    rd(1, 12'h41C); check("R5 private target cpu1", r, 32'h0202_0202);
    rd(0, 12'h400); check("R5 private target cpu0", r, 32'h0101_0101);
    wr(0, 12'h400, 32'h0);
    rd(0, 12'h400); check("R5 write ignored", r, 32'h0101_0101);
    wr(0, 12'h420, 32'hFFFF_0201);
    rd(0, 12'h420); check("R4 target bytes", r, 32'h0303_0201);
    wr(1, 12'h424, 32'h0101_0101);
    rd(0, 12'h424); check("R4 target word 2", r, 32'h0101_0101);
    rd(0, 12'h440); check("R4 absent sources", r, 32'h0);
  endtask

  task automatic t_cfg;
    wr(0, 12'h808, 32'hFFFF_FFFF);
    rd(0, 12'h808); check("R6 odd bits only", r, 32'hAAAA_AAAA);
    rd(0, 12'h80C); check("R6 other word", r, 32'h0);
    wr(0, 12'h808, 32'h0);
    rd(0, 12'h808); check("R6 back to level", r, 32'h0);
  endtask

  task automatic t_level;
    irq_shared[0] = 1'b1;
    @(negedge clk);
    rd(0, 12'h204); check("R7 level sets pending", r, 32'h1);
    wr(0, 12'h284, 32'h1);
    rd(0, 12'h204); check("R7 read after clear", r, 32'h0);
    rd(0, 12'h204); check("R7 set again", r, 32'h1);
    irq_shared[0] = 1'b0;
    wr(0, 12'h284, 32'h1);
    rd(0, 12'h204); check("R7 input low clear", r, 32'h0);
    rd(0, 12'h204); check("R7 stays clear", r, 32'h0);
  endtask

  task automatic t_edge;
    wr(0, 12'h808, 32'h8);
    irq_shared[1] = 1'b1;
    @(negedge clk);
    rd(0, 12'h204); check("R8 rise sets", r, 32'h2);
    wr(0, 12'h284, 32'h2);
    @(negedge clk);
    rd(0, 12'h204); check("R8 held high no reset", r, 32'h0);
    irq_shared[1] = 1'b0;
    @(negedge clk);
    rd(0, 12'h204); check("R8 fall no set", r, 32'h0);
    irq_shared[1] = 1'b1;
    @(negedge clk);
    rd(0, 12'h204); check("R8 second rise", r, 32'h2);
    irq_shared[1] = 1'b0;
    wr(0, 12'h284, 32'h2);
    wr(0, 12'h808, 32'h0);
  endtask

  task automatic t_private;
    irq_private[32 + 3] = 1'b1;
    @(negedge clk);
    rd(1, 12'h200); check("R3 private source own", r, 32'h8);
    rd(0, 12'h200); check("R3 private source other", r, 32'h0);
    irq_private[32 + 3] = 1'b0;
    wr(1, 12'h280, 32'h8);
  endtask

  task automatic t_forward;
    wr(0, 12'h104, 32'h1);
    wr(0, 12'h204, 32'h1);
    check("R10 disabled", 32'(fwd_req), 32'h0);
    wr(0, 12'h000, 32'h1);
    rd(1, 12'h000); check("R10 control read", r, 32'h1);
    check("R10 shared to cpu0", 32'(fwd_req), 32'h1);
    wr(0, 12'h304, 32'h1);
    check("R10 active blocks", 32'(fwd_req), 32'h0);
    wr(0, 12'h384, 32'h1);
    check("R10 active cleared", 32'(fwd_req), 32'h1);
    wr(0, 12'h184, 32'h1);
    check("R10 disabled source", 32'(fwd_req), 32'h0);
    wr(1, 12'h100, 32'h4);
    wr(1, 12'h200, 32'h4);
    check("R10 private cpu1", 32'(fwd_req), 32'h2);
    wr(0, 12'h000, 32'h0);
    check("R10 global off", 32'(fwd_req), 32'h0);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_type();
    t_setclr();
    t_bank();
    t_target();
    t_cfg();
    t_level();
    t_edge();
    t_private();
    t_forward();
    finish_run();
  end

endmodule